// File: doc/BRIEF.md
# Serial Reclocker Output Router

This block is the digital output path that sits behind a serial clock-and-data recovery loop. It chooses one of several serial line inputs, decides on every bit whether the output carries the retimed bit from the recovery loop or the raw selected line bit, and drives a primary serial data output and a secondary serial output. The secondary output can be a second copy of the data, a copy of the recovered clock waveform, or switched off.

The raw path is chosen either because a forcing bypass control is high or because an automatic bypass control is high while the recovery loop reports no lock. The forcing control always wins over the automatic one. An active-low mute freezes the data outputs at their last bit rather than driving a fixed level. A secondary output that carries the clock is not affected by the mute. A switched-off secondary output is shown by a power-down flag and is held at logic 1, which stands for a pull to the supply rail.

Both outputs are registered on the same clock, the recovered bit clock of the system, so the primary and secondary data outputs stay aligned. The recovered clock waveform reaches the block as a sampled bit and goes through the same register stage.

Top module: `reclk_out_route`

## Requirements
- R1: The line select picks input `din_i[sel_i]`: value 0 picks input 0, 1 picks input 1, 2 picks input 2 and 3 picks input 3.
- R2: With `byp_i` high and `mute_n_i` high, the primary output takes the selected line bit, whatever `abyp_i` and `lock_i` say.
- R3: With `byp_i` low and `abyp_i` high, the primary output takes the selected line bit while `lock_i` is low and the retimed bit while `lock_i` is high.
- R4: With both `byp_i` and `abyp_i` low, the primary output takes the retimed bit whether or not the loop is locked.
- R5: While `mute_n_i` is low, the primary output keeps the bit it held before. It is never forced to a constant.
- R6: With `sec_en_i` high and `dc_sel_i` high (data mode), the secondary output follows the same chosen bit as the primary output and is muted, holding its last bit, exactly when the primary output is.
- R7: With `sec_en_i` high and `dc_sel_i` low (clock mode), the secondary output carries `rco_bit_i` even while `mute_n_i` is low.
- R8: With `sec_en_i` low, `sec_o` is 1 and `sec_pd_o` is 1 whatever `dc_sel_i` is, and the primary output obeys the mute alone. With `sec_en_i` high, `sec_pd_o` is 0.
- R9: Every output changes only on a rising clock edge and reflects the inputs sampled at that edge: a latency of one cycle.
- R10: While `rst_n` is low, `pri_o`, `sec_o` and `sec_pd_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_i | input | NUM_IN (4) | Serial line inputs, one bit per line |
| sel_i | input | SEL_W (2) | Line select |
| rt_bit_i | input | 1 | Retimed data bit from the recovery loop |
| rco_bit_i | input | 1 | Sampled recovered-clock waveform |
| lock_i | input | 1 | Recovery loop locked |
| byp_i | input | 1 | Forced bypass, overrides the automatic bypass |
| abyp_i | input | 1 | Automatic bypass while unlocked |
| mute_n_i | input | 1 | Data mute, active low (hold last bit) |
| sec_en_i | input | 1 | Secondary output enable; low powers it down |
| dc_sel_i | input | 1 | Secondary mode: 1 data copy, 0 clock |
| pri_o | output | 1 | Primary serial data output |
| sec_o | output | 1 | Secondary serial output |
| sec_pd_o | output | 1 | Secondary output powered down |

## Verification
Random stimulus sets the line bits, the retimed and clock bits and all control pins on every cycle on its own, so each combination of forced bypass, automatic bypass and lock is met with line and retimed bits that differ. Only a mismatch between those two bits shows which path was taken. Long mute runs with changing inputs separate a hold from a zero level. Runs that switch the secondary mode while muted separate the clock path, which keeps moving, from the data path, which freezes. Directed steps walk the line select over all four values with only one line high, check the power-down level against both settings of the data/clock select, and look at the outputs just before and just after an edge to pin down the one-cycle latency.

// File: rtl/ror_pkg.sv
package ror_pkg;

   typedef enum logic [1:0] {
      SEC_OFF  = 2'd0,
      SEC_DATA = 2'd1,
      SEC_CLK  = 2'd2
   } sec_mode_e;

   function automatic sec_mode_e decode_sec(input logic en, input logic dc);
      if (!en)
         return SEC_OFF;
      else if (dc)
         return SEC_DATA;
      else
         return SEC_CLK;
   endfunction

endpackage

// File: rtl/ror_in_sel.sv
module ror_in_sel #(
   parameter int NUM_IN = 4,
   localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic [NUM_IN-1:0] din_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              bit_o
);

   localparam bit POW2 = ((1 << SEL_W) == NUM_IN);

   generate
      if (NUM_IN < 2) begin : g_bad_count
         $error("ror_in_sel: NUM_IN must be at least 2");
      end

      if (POW2) begin : g_full
         // every select code maps to a real line
         assign bit_o = din_i[sel_i];
      end else begin : g_guarded
         // codes past the last line give a quiet 0
         always_comb begin
            bit_o = 1'b0;
            for (int k = 0; k < NUM_IN; k++) begin
               if (sel_i == SEL_W'(k))
                  bit_o = din_i[k];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ror_path_pick.sv
module ror_path_pick (
   input  logic line_bit_i,
   input  logic rt_bit_i,
   input  logic lock_i,
   input  logic byp_i,
   input  logic abyp_i,
   output logic raw_sel_o,
   output logic bit_o
);

   // forced bypass first; automatic bypass only counts while unlocked
   always_comb begin
      if (byp_i)
         raw_sel_o = 1'b1;
      else if (abyp_i)
         raw_sel_o = ~lock_i;
      else
         raw_sel_o = 1'b0;
      bit_o = raw_sel_o ? line_bit_i : rt_bit_i;
   end

endmodule

// File: rtl/ror_out_stage.sv
module ror_out_stage
   import ror_pkg::*;
#(
   parameter logic PD_LEVEL  = 1'b1,
   parameter logic RST_LEVEL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_i,
   input  logic      rco_bit_i,
   input  logic      mute_n_i,
   input  sec_mode_e mode_i,
   output logic      pri_o,
   output logic      sec_o,
   output logic      pd_o
);

   logic pri_d, sec_d, pd_d;

   always_comb begin
      pri_d = mute_n_i ? bit_i : pri_o;
      pd_d  = 1'b0;
      unique case (mode_i)
         SEC_OFF: begin
            sec_d = PD_LEVEL;
            pd_d  = 1'b1;
         end
         SEC_DATA: sec_d = mute_n_i ? bit_i : sec_o;
         SEC_CLK:  sec_d = rco_bit_i;
         default:  sec_d = sec_o;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_o <= RST_LEVEL;
         sec_o <= RST_LEVEL;
         pd_o  <= 1'b0;
      end else begin
         pri_o <= pri_d;
         sec_o <= sec_d;
         pd_o  <= pd_d;
      end
   end

endmodule

// File: rtl/reclk_out_route.sv
module reclk_out_route
   import ror_pkg::*;
#(
   parameter int   NUM_IN   = 4,
   parameter logic PD_LEVEL = 1'b1,
   localparam int  SEL_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] din_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              rt_bit_i,
   input  logic              rco_bit_i,
   input  logic              lock_i,
   input  logic              byp_i,
   input  logic              abyp_i,
   input  logic              mute_n_i,
   input  logic              sec_en_i,
   input  logic              dc_sel_i,
   output logic              pri_o,
   output logic              sec_o,
   output logic              sec_pd_o
);

   logic      line_bit;
   logic      raw_sel;
   logic      chosen_bit;
   sec_mode_e sec_mode;

   ror_in_sel #(.NUM_IN(NUM_IN)) u_sel (
      .din_i (din_i),
      .sel_i (sel_i),
      .bit_o (line_bit)
   );

   ror_path_pick u_pick (
      .line_bit_i (line_bit),
      .rt_bit_i   (rt_bit_i),
      .lock_i     (lock_i),
      .byp_i      (byp_i),
      .abyp_i     (abyp_i),
      .raw_sel_o  (raw_sel),
      .bit_o      (chosen_bit)
   );

   assign sec_mode = decode_sec(sec_en_i, dc_sel_i);

   ror_out_stage #(.PD_LEVEL(PD_LEVEL), .RST_LEVEL(1'b0)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_i     (chosen_bit),
      .rco_bit_i (rco_bit_i),
      .mute_n_i  (mute_n_i),
      .mode_i    (sec_mode),
      .pri_o     (pri_o),
      .sec_o     (sec_o),
      .pd_o      (sec_pd_o)
   );

endmodule

// File: rtl/reclk_out_route_chk.sv
module reclk_out_route_chk #(
   parameter int  NUM_IN = 4,
   localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_IN-1:0] din_i,
   input logic [SEL_W-1:0]  sel_i,
   input logic              rt_bit_i,
   input logic              rco_bit_i,
   input logic              lock_i,
   input logic              byp_i,
   input logic              abyp_i,
   input logic              mute_n_i,
   input logic              sec_en_i,
   input logic              dc_sel_i,
   input logic              pri_o,
   input logic              sec_o,
   input logic              sec_pd_o
);

   logic line_c;
   assign line_c = (int'(sel_i) < NUM_IN) ? din_i[sel_i] : 1'b0;

   p_force_byp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_i && mute_n_i) |=> (pri_o == $past(line_c)));

   p_auto_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_i && abyp_i && !lock_i && mute_n_i) |=> (pri_o == $past(line_c)));

   p_auto_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_i && abyp_i && lock_i && mute_n_i) |=> (pri_o == $past(rt_bit_i)));

   p_no_byp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_i && !abyp_i && mute_n_i) |=> (pri_o == $past(rt_bit_i)));

   p_mute_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_n_i |=> $stable(pri_o));

   p_sec_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en_i && dc_sel_i && mute_n_i) |=> (sec_o == pri_o));

   p_sec_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en_i && !dc_sel_i) |=> (sec_o == $past(rco_bit_i)));

   p_sec_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_en_i |=> (sec_o && sec_pd_o));

   p_sec_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_en_i |=> !sec_pd_o);

   always_comb begin
      if (!rst_n) begin
         a_reset_r10: assert (!pri_o && !sec_o && !sec_pd_o);
      end
   end

endmodule

bind reclk_out_route reclk_out_route_chk #(.NUM_IN(NUM_IN)) u_chk (.*);

// File: tb/sim_reclk_out_route.sv
module sim_reclk_out_route;

   localparam int NUM_IN = 4;
   localparam int SEL_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_IN-1:0] din = '0;
   logic [SEL_W-1:0]  sel = '0;
   logic rt = 0, rco = 0, lock = 0, byp = 0, abyp = 0;
   logic mute_n = 1, sec_en = 1, dc = 1;
   logic pri, sec, pd;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // model state
   logic m_pri = 0, m_sec = 0, m_pd = 0;

   always #10 clk = ~clk;

   reclk_out_route #(.NUM_IN(NUM_IN)) u0 (
      .clk(clk), .rst_n(rst_n), .din_i(din), .sel_i(sel),
      .rt_bit_i(rt), .rco_bit_i(rco), .lock_i(lock),
      .byp_i(byp), .abyp_i(abyp), .mute_n_i(mute_n),
      .sec_en_i(sec_en), .dc_sel_i(dc),
      .pri_o(pri), .sec_o(sec), .sec_pd_o(pd)
   );

   function automatic logic chosen(input logic [NUM_IN-1:0] d, input logic [SEL_W-1:0] s,
                                   input logic r, input logic lk, input logic b, input logic ab);
      logic raw;
      raw = b | (ab & ~lk);
      return raw ? d[s] : r;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // compute the model for the currently driven inputs (one edge later)
   task automatic model_edge();
      logic c;
      c = chosen(din, sel, rt, lock, byp, abyp);
      if (mute_n) m_pri = c;
      if (!sec_en) begin m_sec = 1'b1; m_pd = 1'b1; end
      else begin
         m_pd = 1'b0;
         if (dc) begin if (mute_n) m_sec = c; end
         else m_sec = rco;
      end
   endtask

   function automatic string pri_tag();
      if (!mute_n) return "R5";
      if (byp) return "R2";
      if (abyp) return "R3";
      return "R4";
   endfunction

   function automatic string sec_tag();
      if (!sec_en) return "R8";
      if (dc) return "R6";
      return "R7";
   endfunction

   // inputs are driven after a negedge; outputs sampled at the next negedge
   task automatic step(input bit chk);
      string tp, ts;
      tp = pri_tag();
      ts = sec_tag();
      model_edge();
      @(posedge clk);
      @(negedge clk);
      if (chk) begin
         check(tp, pri, m_pri);
         check(ts, sec, m_sec);
         check("R8", pd, m_pd);
      end
   endtask

   task automatic rand_in(input int mute_pct);
      din    = NUM_IN'($urandom);
      sel    = SEL_W'($urandom);
      rt     = 1'($urandom);
      rco    = 1'($urandom);
      lock   = 1'($urandom);
      byp    = ($urandom % 4) == 0;
      abyp   = 1'($urandom);
      mute_n = ($urandom % 100) >= mute_pct;
      sec_en = ($urandom % 5) != 0;
      dc     = 1'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C1A));
      // R10: reset state
      din = '1; rt = 1; rco = 1; sec_en = 0;
      repeat (3) @(negedge clk);
      check("R10", pri, 1'b0);
      check("R10", sec, 1'b0);
      check("R10", pd,  1'b0);
      rst_n = 1'b1;
      sec_en = 1; din = '0; rt = 0; rco = 0;
      step(1'b0);
      m_pri = pri; m_sec = sec; m_pd = pd;

      // R1: one-hot line, walk the select under forced bypass
      byp = 1; mute_n = 1; dc = 1;
      for (int s = 0; s < NUM_IN; s++) begin
         din = NUM_IN'(1) << s;
         rt  = 1'b0;
         for (int q = 0; q < NUM_IN; q++) begin
            sel = SEL_W'(q);
            step(1'b1);
            check("R1", pri, (s == q));
         end
      end

      // R3: automatic bypass, line and retimed bits differ
      byp = 0; abyp = 1; sel = 2; din = 4'b0100; rt = 0;
      lock = 0; step(1'b1); check("R3", pri, 1'b1);
      lock = 1; step(1'b1); check("R3", pri, 1'b0);
      // R4: no bypass, unlocked still gives retimed bit
      abyp = 0; lock = 0; rt = 0; step(1'b1); check("R4", pri, 1'b0);
      // R2: forced bypass beats locked automatic bypass setting
      byp = 1; abyp = 0; lock = 1; step(1'b1); check("R2", pri, 1'b1);

      // R5/R6/R7: mute with clock-mode secondary still toggling
      byp = 0; rt = 1; step(1'b1);
      mute_n = 0; dc = 0;
      for (int k = 0; k < 4; k++) begin
         rt = ~rt; rco = k[0];
         step(1'b1);
         check("R5", pri, 1'b1);
         check("R7", sec, k[0]);
      end
      dc = 1; rco = 0; step(1'b1);
      check("R6", sec, 1'b1);
      mute_n = 1;

      // R8: power-down with both data/clock settings
      sec_en = 0; dc = 0; rco = 0; step(1'b1); check("R8", sec, 1'b1);
      dc = 1; mute_n = 0; step(1'b1); check("R8", pd, 1'b1);
      mute_n = 1; sec_en = 1;

      // R9: no change before the edge, change after it
      byp = 0; abyp = 0; rt = 0; step(1'b1);
      rt = 1; model_edge();
      #2; check("R9", pri, 1'b0);
      @(posedge clk); #2; check("R9", pri, 1'b1);
      @(negedge clk);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         rand_in((i / 500) % 2 == 1 ? 60 : 15);
         step(1'b1);
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule